// File: doc/BRIEF.md
# Triggered Scan Acquisition Controller

This block paces a multi-channel acquisition. Each clock cycle is one period of the timebase. While the block is acquiring, an interval timer fires every `cfg_interval` cycles. On each firing it starts one scan by pulsing `scan_start`. A scan then yields one `store` pulse per channel. The block produces a sample only in a cycle in which the converter does not report `scan_busy`. A scan that is still running when the timer fires causes that firing to be dropped.

The block has four acquisition modes:

- **Post-trigger:** the block waits for a trigger, then takes a fixed burst of scans.
- **Pre-trigger:** the block scans from the start command and stops on an accepted trigger. A scan that is in progress at that moment runs to completion.
- **Middle-trigger:** the block scans before the trigger and keeps going until a set number of scans after it have been counted.
- **Delay-trigger:** a trigger starts a tick-driven delay countdown, and a post-trigger burst follows.

Post-trigger and delay-trigger can re-arm after each burst to serve several triggers. A minimum count of completed scans can be required before a trigger is taken. `done` is raised when the whole sequence has finished. A synchronous `clear` drops everything back to idle.

Top module: `scan_acq_ctrl`

## Requirements
- R1: While acquiring, a scan is launched when the interval timer fires. Firings are `cfg_interval` cycles apart; a value of 0 behaves as 1. The first firing falls on the first acquiring cycle. A firing that meets a scan still in progress is dropped, and no scan is launched for it. `scan_start` is high for one cycle, in the cycle after the launch decision.
- R2: Every scan gives exactly `cfg_chans` `store` pulses; a value of 0 behaves as 1. A pulse appears in the cycle after each active-scan cycle in which `scan_busy` was low. Scans of 3 channels give 3 pulses each.
- R3: `cfg_mode`=0 (post): `start` arms the block and launches no scan. After `trig`, exactly `cfg_post_scans` scans are launched, and then `done` rises.
- R4: `cfg_mode`=1 (pre): scanning begins at `start`. An accepted `trig` stops all further launches, including a launch due in the same cycle. A scan in progress completes, and `done` rises after it.
- R5: With `cfg_pre_gate`=1, `trig` in pre or middle mode is ignored until `cfg_pre_scans` scans have completed. With `cfg_pre_gate`=0 it is accepted at any time.
- R6: `cfg_mode`=2 (middle): after an accepted `trig`, scanning continues at the same cadence until `cfg_post_scans` scans are counted after the trigger. A scan in progress at the trigger, or one launched in the trigger cycle, counts as the first of them.
- R7: `cfg_mode`=3 (delay): `trig` loads `cfg_delay`. Each `dly_tick` lowers it by one. When it reaches zero, a post-trigger burst begins.
- R8: With `cfg_retrig_en`=1 in modes 0 and 3, the block re-arms after each burst until `cfg_retrig_num` bursts have run (0 or 1 means one burst), and then raises `done`.
- R9: A `trig` during a burst, a delay countdown or the draining scan is ignored. `done` stays high until `start` or `clear`, and no scan or store occurs while it is high.
- R10: `clear` (or `rst`) returns the block to idle in the next cycle, with all outputs low. A `start` that arrives while a sequence is running is ignored.
- R11: A `start` issued while `done` is high begins a new sequence with fresh counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous return to idle |
| start | input | 1 | Begin a sequence |
| trig | input | 1 | Trigger event pulse |
| dly_tick | input | 1 | Delay countdown clock enable |
| scan_busy | input | 1 | Converter not ready for the next sample |
| cfg_mode | input | 2 | 0 post, 1 pre, 2 middle, 3 delay |
| cfg_interval | input | TMR_W | Cycles between scan launches |
| cfg_chans | input | CH_W | Samples per scan |
| cfg_pre_scans | input | SCAN_W | Completed scans required before a trigger |
| cfg_pre_gate | input | 1 | Enable the minimum-scan trigger gate |
| cfg_post_scans | input | SCAN_W | Scans after the trigger |
| cfg_delay | input | DLY_W | Delay countdown preload |
| cfg_retrig_en | input | 1 | Enable re-arming |
| cfg_retrig_num | input | RTG_W | Number of bursts |
| scan_start | output | 1 | Scan launch pulse |
| store | output | 1 | Per-sample store strobe |
| done | output | 1 | Sequence finished |

## Verification
A trigger and a timer-driven scan launch can fall in the same cycle. The bench causes this on purpose by waiting for a `scan_start` and then driving `trig` so that it is sampled exactly one interval later.

In pre mode the launch due in that cycle must be suppressed, so the scan count must not grow. In middle mode the launch must count as the first post-trigger scan. A second middle-mode run places the trigger inside a scan, to judge the in-progress case. A behavioural reference model compares all three outputs on every clock, and directed counts check each case.

// File: rtl/scan_acq_pkg.sv
package scan_acq_pkg;
  typedef enum logic [1:0] {
    MODE_POST  = 2'd0,
    MODE_PRE   = 2'd1,
    MODE_MID   = 2'd2,
    MODE_DELAY = 2'd3
  } acq_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DELAY,
    ST_PRE,
    ST_POST,
    ST_DRAIN,
    ST_DONE
  } acq_state_e;
endpackage

// File: rtl/scan_interval_timer.sv
module scan_interval_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] interval,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt == '0)
      cnt <= (interval == '0) ? '0 : interval - W'(1);
    else
      cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/scan_sample_seq.sv
module scan_sample_seq #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  input  logic            busy,
  input  logic [CH_W-1:0] chans,
  output logic            in_scan,
  output logic            sample,
  output logic            last
);
  logic [CH_W-1:0] idx;
  logic [CH_W-1:0] last_idx;

  assign last_idx = (chans == '0) ? '0 : chans - CH_W'(1);
  assign sample   = in_scan && !busy;
  assign last     = sample && (idx >= last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_scan <= 1'b0;
      idx     <= '0;
    end else if (launch) begin
      in_scan <= 1'b1;
      idx     <= '0;
    end else if (sample) begin
      if (last) in_scan <= 1'b0;
      else      idx     <= idx + CH_W'(1);
    end
  end
endmodule

// File: rtl/trig_delay_cnt.sv
module trig_delay_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= value;
    else if (dec && !zero)
      cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/scan_acq_ctrl.sv
module scan_acq_ctrl
  import scan_acq_pkg::*;
#(
  parameter int TMR_W  = 24,
  parameter int SCAN_W = 16,
  parameter int DLY_W  = 16,
  parameter int CH_W   = 4,
  parameter int RTG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              start,
  input  logic              trig,
  input  logic              dly_tick,
  input  logic              scan_busy,
  input  logic [1:0]        cfg_mode,
  input  logic [TMR_W-1:0]  cfg_interval,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic [SCAN_W-1:0] cfg_pre_scans,
  input  logic              cfg_pre_gate,
  input  logic [SCAN_W-1:0] cfg_post_scans,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic              cfg_retrig_en,
  input  logic [RTG_W-1:0]  cfg_retrig_num,
  output logic              scan_start,
  output logic              store,
  output logic              done
);
  localparam int RN_W = RTG_W + 1;

  acq_state_e        st;
  acq_mode_e         mode;
  logic [SCAN_W-1:0] pre_done;
  logic [SCAN_W-1:0] post_started;
  logic [RTG_W-1:0]  bursts_done;
  logic [RN_W-1:0]   bursts_nxt;
  logic              ss_q, sto_q;
  logic              flush, run, tick, in_scan, sample, last, dly_zero;
  logic              launch, pre_ok, take_trig, post_full, burst_end;
  logic              more_bursts, dly_load, dly_dec, rearm_mode;

  assign flush = rst || clear;
  assign mode  = acq_mode_e'(cfg_mode);
  assign run   = (st == ST_PRE) || (st == ST_POST);

  scan_interval_timer #(.W(TMR_W)) i_timer (
    .clk(clk), .rst(flush), .run(run), .interval(cfg_interval), .tick(tick)
  );

  scan_sample_seq #(.CH_W(CH_W)) i_seq (
    .clk(clk), .rst(flush), .launch(launch), .busy(scan_busy), .chans(cfg_chans),
    .in_scan(in_scan), .sample(sample), .last(last)
  );

  trig_delay_cnt #(.W(DLY_W)) i_delay (
    .clk(clk), .rst(flush), .load(dly_load), .dec(dly_dec), .value(cfg_delay),
    .zero(dly_zero)
  );

  // trigger acceptance, gated by the count of completed pre-trigger scans
  assign pre_ok     = !cfg_pre_gate || (pre_done >= cfg_pre_scans);
  assign take_trig  = (st == ST_PRE) && trig && pre_ok;
  assign post_full  = (post_started >= cfg_post_scans);
  assign burst_end  = (st == ST_POST) && post_full && !in_scan;
  assign dly_load   = (st == ST_ARM) && trig && (mode == MODE_DELAY);
  assign dly_dec    = (st == ST_DELAY) && dly_tick;
  assign rearm_mode = (mode == MODE_POST) || (mode == MODE_DELAY);
  assign bursts_nxt = {1'b0, bursts_done} + RN_W'(1);
  assign more_bursts = cfg_retrig_en && rearm_mode &&
                       (bursts_nxt < {1'b0, cfg_retrig_num});

  always_comb begin
    case (st)
      ST_PRE:  launch = tick && !in_scan && !(take_trig && mode == MODE_PRE);
      ST_POST: launch = tick && !in_scan && !post_full;
      default: launch = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (flush) begin
      st           <= ST_IDLE;
      pre_done     <= '0;
      post_started <= '0;
      bursts_done  <= '0;
      ss_q         <= 1'b0;
      sto_q        <= 1'b0;
    end else begin
      ss_q  <= launch;
      sto_q <= sample;
      unique case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st <= (mode == MODE_PRE || mode == MODE_MID) ? ST_PRE : ST_ARM;
            pre_done     <= '0;
            post_started <= '0;
            bursts_done  <= '0;
          end
        end
        ST_ARM: begin
          if (trig) begin
            st <= (mode == MODE_DELAY) ? ST_DELAY : ST_POST;
            post_started <= '0;
          end
        end
        ST_DELAY: begin
          if (dly_zero) st <= ST_POST;
        end
        ST_PRE: begin
          if (last && (pre_done < cfg_pre_scans))
            pre_done <= pre_done + SCAN_W'(1);
          if (take_trig) begin
            if (mode == MODE_PRE) begin
              st <= ST_DRAIN;
            end else begin
              st <= ST_POST;
              post_started <= (in_scan || launch) ? SCAN_W'(1) : '0;
            end
          end
        end
        ST_DRAIN: begin
          if (!in_scan) st <= ST_DONE;
        end
        ST_POST: begin
          if (launch) post_started <= post_started + SCAN_W'(1);
          if (burst_end) begin
            bursts_done <= bursts_done + RTG_W'(1);
            st <= more_bursts ? ST_ARM : ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign scan_start = ss_q;
  assign store      = sto_q;
  assign done       = (st == ST_DONE);
endmodule

// File: rtl/scan_acq_chk.sv
module scan_acq_chk (
  input logic clk,
  input logic rst,
  input logic clear,
  input logic start,
  input logic scan_busy,
  input logic scan_start,
  input logic store,
  input logic done
);
  // R2: a sample is stored only after a cycle in which the converter was ready
  a_r2_store_when_ready: assert property (@(posedge clk) disable iff (rst)
    store |-> !$past(scan_busy));

  // R1: a scan occupies at least one cycle, so launches never come back to back
  a_r1_launch_spaced: assert property (@(posedge clk) disable iff (rst)
    scan_start |=> !scan_start);

  // R9: done persists until a new start or a clear
  a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !start && !clear) |=> done);

  // R9: no activity while done
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!scan_start && !store));

  // R10: clear leaves every output low in the next cycle
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!done && !scan_start && !store));
endmodule

bind scan_acq_ctrl scan_acq_chk i_chk (
  .clk(clk), .rst(rst), .clear(clear), .start(start), .scan_busy(scan_busy),
  .scan_start(scan_start), .store(store), .done(done)
);

// File: tb/test_scan_acq_ctrl.sv
`timescale 1ns/1ps
module test_scan_acq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0, start = 1'b0, trig = 1'b0, dly_tick = 1'b0, scan_busy = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [23:0] cfg_interval = 24'd8;
  logic [3:0]  cfg_chans = 4'd3;
  logic [15:0] cfg_pre_scans = 16'd0;
  logic        cfg_pre_gate = 1'b0;
  logic [15:0] cfg_post_scans = 16'd4;
  logic [15:0] cfg_delay = 16'd0;
  logic        cfg_retrig_en = 1'b0;
  logic [7:0]  cfg_retrig_num = 8'd0;
  logic scan_start, store, done;

  always #5 clk = ~clk;

  scan_acq_ctrl i_scan_acq_ctrl (
    .clk(clk), .rst(rst), .clear(clear), .start(start), .trig(trig),
    .dly_tick(dly_tick), .scan_busy(scan_busy), .cfg_mode(cfg_mode),
    .cfg_interval(cfg_interval), .cfg_chans(cfg_chans),
    .cfg_pre_scans(cfg_pre_scans), .cfg_pre_gate(cfg_pre_gate),
    .cfg_post_scans(cfg_post_scans), .cfg_delay(cfg_delay),
    .cfg_retrig_en(cfg_retrig_en), .cfg_retrig_num(cfg_retrig_num),
    .scan_start(scan_start), .store(store), .done(done)
  );

  integer checks = 0, failures = 0;
  integer cyc = 0, pcyc = 0, last_ss = 0, gap = 0;
  integer n_ss = 0, n_sto = 0;
  logic busy_en = 1'b0, tick_en = 1'b0, finished = 1'b0;

  task automatic chk(input logic ok, input string req, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // converter busy pattern and delay tick, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    scan_busy = busy_en && (cyc % 5 == 2);
    dly_tick  = tick_en && (cyc % 2 == 0);
  end

  // ---------------- behavioural reference model ----------------
  localparam integer S_IDLE = 0, S_ARM = 1, S_DLY = 2, S_PRE = 3, S_POST = 4,
                     S_DRN = 5, S_DONE = 6;
  integer m_st = 0, m_tmr = 0, m_idx = 0, m_pre = 0, m_post = 0, m_bur = 0, m_dly = 0;
  integer o_st, o_in, o_post, o_dly, nch, iv;
  logic m_in = 1'b0, e_ss = 1'b0, e_sto = 1'b0;
  logic smp, lst, runm, tck, take, lau;

  always @(posedge clk) begin
    if (rst || clear) begin
      m_st = S_IDLE; m_tmr = 0; m_in = 0; m_idx = 0; m_pre = 0; m_post = 0;
      m_bur = 0; m_dly = 0; e_ss = 0; e_sto = 0;
    end else begin
      nch  = (cfg_chans == 0) ? 1 : cfg_chans;
      iv   = (cfg_interval == 0) ? 1 : cfg_interval;
      smp  = m_in && !scan_busy;
      lst  = smp && (m_idx == nch - 1);
      runm = (m_st == S_PRE) || (m_st == S_POST);
      tck  = runm && (m_tmr == 0);
      take = (m_st == S_PRE) && trig && (!cfg_pre_gate || m_pre >= cfg_pre_scans);
      lau  = 0;
      if (m_st == S_PRE)       lau = tck && !m_in && !(take && cfg_mode == 1);
      else if (m_st == S_POST) lau = tck && !m_in && (m_post < cfg_post_scans);
      e_ss = lau; e_sto = smp;
      o_st = m_st; o_in = m_in; o_post = m_post; o_dly = m_dly;
      if (!runm) m_tmr = 0; else if (m_tmr == 0) m_tmr = iv - 1; else m_tmr = m_tmr - 1;
      if (lau) begin m_in = 1; m_idx = 0; end
      else if (smp) begin if (lst) m_in = 0; else m_idx = m_idx + 1; end
      if (o_st == S_DLY && dly_tick && o_dly > 0) m_dly = o_dly - 1;
      case (o_st)
        S_IDLE, S_DONE: if (start) begin
          m_st = (cfg_mode == 1 || cfg_mode == 2) ? S_PRE : S_ARM;
          m_pre = 0; m_post = 0; m_bur = 0;
        end
        S_ARM: if (trig) begin
          m_post = 0;
          if (cfg_mode == 3) begin m_st = S_DLY; m_dly = cfg_delay; end
          else m_st = S_POST;
        end
        S_DLY: if (o_dly == 0) m_st = S_POST;
        S_PRE: begin
          if (lst && m_pre < cfg_pre_scans) m_pre = m_pre + 1;
          if (take) begin
            if (cfg_mode == 1) m_st = S_DRN;
            else begin m_st = S_POST; m_post = (o_in || lau) ? 1 : 0; end
          end
        end
        S_DRN: if (!o_in) m_st = S_DONE;
        S_POST: begin
          if (lau) m_post = m_post + 1;
          if (o_post >= cfg_post_scans && !o_in) begin
            m_bur = m_bur + 1;
            m_st = (cfg_retrig_en && (cfg_mode == 0 || cfg_mode == 3) && m_bur < cfg_retrig_num)
                   ? S_ARM : S_DONE;
          end
        end
        default: m_st = S_IDLE;
      endcase
    end
  end

  // per-cycle comparison, sampled after the edge has settled
  always @(posedge clk) begin
    #2;
    pcyc++;
    if (!rst) begin
      chk(scan_start === e_ss, "R1 scan_start", scan_start, e_ss);
      chk(store === e_sto, "R2 store", store, e_sto);
      chk(done === (m_st == S_DONE), "R9 done", done, m_st == S_DONE);
    end
    if (scan_start) begin gap = pcyc - last_ss; last_ss = pcyc; n_ss++; end
    if (store) n_sto++;
  end

  task automatic wait_cyc(input integer n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start;
    start = 1; @(negedge clk); start = 0;
  endtask
  task automatic pulse_trig;
    trig = 1; @(negedge clk); trig = 0;
  endtask
  task automatic wait_done;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask
  task automatic wait_launch;
    do @(negedge clk); while (!scan_start);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!scan_start && !store && !done, "R10 reset outputs low", {scan_start, store, done}, 0);
    busy_en = 1;

    // post mode with a second trigger during the burst
    cfg_mode = 0; cfg_post_scans = 4; n_ss = 0; n_sto = 0;
    pulse_start; wait_cyc(20);
    chk(n_ss == 0, "R3 armed, no scans before trigger", n_ss, 0);
    pulse_trig; wait_cyc(10); pulse_trig;
    wait_done;
    chk(done, "R3 done after burst", done, 1);
    chk(n_ss == 4, "R3/R9 scan count", n_ss, 4);
    chk(n_sto == 12, "R2 store count 3 ch x 4", n_sto, 12);
    chk(gap == 8, "R1 launch spacing", gap, 8);

    // pre mode, gated; early trigger ignored; trigger aligned with a launch
    cfg_mode = 1; cfg_pre_scans = 3; cfg_pre_gate = 1;
    pulse_start; wait_cyc(5); pulse_trig; wait_cyc(3);
    chk(!done, "R5 early trigger ignored", done, 0);
    wait_cyc(30);
    wait_launch; wait_cyc(7); n_ss = 0; pulse_trig;
    wait_done;
    chk(done, "R4 pre done", done, 1);
    chk(n_ss == 0, "R4 launch in trigger cycle suppressed", n_ss, 0);

    // pre mode, ungated: trigger accepted immediately
    cfg_pre_gate = 0;
    pulse_start; wait_cyc(2); pulse_trig; wait_cyc(12);
    chk(done, "R5 ungated trigger accepted", done, 1);

    // middle mode, trigger in a launch cycle
    cfg_mode = 2; cfg_pre_scans = 2; cfg_pre_gate = 1; cfg_post_scans = 3;
    pulse_start; wait_cyc(40);
    wait_launch; wait_cyc(7); n_ss = 0; pulse_trig;
    wait_done;
    chk(n_ss == 3, "R6 launch in trigger cycle counted", n_ss, 3);

    // middle mode, trigger inside a scan
    pulse_start; wait_cyc(40);
    wait_launch; n_ss = 0; pulse_trig;
    wait_done;
    chk(n_ss == 2, "R6 scan in progress counted", n_ss, 2);

    // delay mode with re-trigger
    cfg_mode = 3; cfg_post_scans = 2; cfg_delay = 6; cfg_retrig_en = 1; cfg_retrig_num = 2;
    tick_en = 1; n_ss = 0;
    pulse_start; pulse_trig; wait_cyc(3); pulse_trig; wait_cyc(5);
    chk(n_ss == 0, "R7 no scan during delay", n_ss, 0);
    wait_cyc(40);
    chk(n_ss == 2 && !done, "R8 first burst then re-armed", n_ss, 2);
    pulse_trig; wait_done;
    chk(n_ss == 4 && done, "R8 second burst then done", n_ss, 4);
    tick_en = 0; cfg_retrig_en = 0;

    // overrun: interval shorter than a scan
    cfg_mode = 0; cfg_interval = 2; cfg_post_scans = 3; n_ss = 0;
    pulse_start; pulse_trig; wait_done;
    chk(n_ss == 3 && done, "R1 overrun firings dropped", n_ss, 3);

    // clear during a burst, with an ignored start
    cfg_interval = 8; cfg_post_scans = 10;
    pulse_start; pulse_trig; wait_cyc(20); pulse_start; wait_cyc(3);
    clear = 1; @(negedge clk); clear = 0;
    chk(!scan_start && !store && !done, "R10 clear to idle", {scan_start, store, done}, 0);
    n_ss = 0; wait_cyc(20);
    chk(n_ss == 0, "R10 idle after clear", n_ss, 0);

    // restart from done, zero channels behaves as one
    cfg_chans = 0; cfg_post_scans = 2; n_ss = 0; n_sto = 0;
    pulse_start; pulse_trig; wait_done;
    chk(done, "R11 first run done", done, 1);
    pulse_start;
    chk(!done, "R11 start leaves done", done, 0);
    pulse_trig; wait_done;
    chk(n_ss == 4 && done, "R11 second run scans", n_ss, 4);
    chk(n_sto == 4, "R2 zero channels as one", n_sto, 4);

    wait_cyc(5);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule